// File: doc/BRIEF.md
# Trap and Debug Sequencing Controller

This block is the control state machine of a small in-order core. Each cycle it looks at the instruction in the decode stage and decides whether that instruction simply retires or whether the core must change course. A change of course can be a synchronous exception, a vectored interrupt, an entry into debug mode, a single-step stop, a flush after a critical CSR update, or a sleep on a wait-for-interrupt. For each change it issues the actions in order: clear and hold fetch, redirect the PC, and strobe the cause, trap value and debug-PC saves.

Arbitration is fixed. The instruction that is completing comes first, together with any exception it raises. A debug request comes next, and an interrupt comes last. A multicycle instruction that is still running is never cut short. While the core is in debug mode, interrupts and further debug requests are masked. All control outputs except the register-file write enable are registered. Each decision therefore appears at the ports in the cycle after the clock edge that made it.

Top module: `trap_dbg_ctrl`

## Requirements
- R1: During reset, and in the first cycle after reset is released, `fetch_halt_o` is 1, `debug_mode_o` is 0 and no strobe is active. In the second cycle after release, one redirect with `pc_sel_o` = 0 (boot) appears and fetch is released. From then on, no strobe is active while the inputs are quiet.
- R2: While `id_valid_i` and `id_busy_i` are both high, no redirect, fetch clear or halt is issued, even if an interrupt, a debug request or single step is pending. Requests are served once the instruction is no longer busy.
- R3: When an instruction completes with an exception while a debug request and an interrupt are both pending, the exception is served first. The debug request follows, and the interrupt only after that.
- R4: A completing instruction with an exception, outside debug mode and without single step, gives one cycle later a redirect with `pc_sel_o` = 2 (trap base, not vectored). The same cycle carries `csr_save_cause_o`, a fetch clear, and `cause_o` = {0, code}. The code is 2 for an illegal instruction, 5 for a load fault and 7 for a store fault, with priority illegal > load > store. `tval_o` holds the instruction word for an illegal instruction and the faulting address for a load or store fault.
- R5: A pending interrupt taken at an instruction boundary first gives one cycle of fetch clear with halt. The next cycle gives a redirect with `pc_sel_o` = 3 (vectored), `csr_save_cause_o`, `cause_o` = {1, zero-extended interrupt id} and `tval_o` = 0.
- R6: A debug request taken at a boundary first gives one cycle of fetch clear with halt. If the request is still high in that cycle, the next cycle gives a redirect with `pc_sel_o` = 4 and `csr_save_dpc_o`. In that cycle `dpc_sel_o` = 0 (address of the next instruction) and `debug_mode_o` rises.
- R7: If the debug request is low during the halt cycle of R6, debug entry is abandoned. No debug-PC save, no redirect and no debug mode follow, and fetch is released.
- R8: In debug mode, pending interrupts and debug requests have no effect. A completing instruction with an exception redirects with `pc_sel_o` = 5 and saves no cause. A completing debug-return redirects with `pc_sel_o` = 6 and clears `debug_mode_o`.
- R9: A completing breakpoint instruction outside debug mode gives one halt cycle. It then enters debug mode with `pc_sel_o` = 4, `csr_save_dpc_o` and `dpc_sel_o` = 1 (address of the current instruction), and saves no cause.
- R10: With single step enabled outside debug mode, exactly one instruction completes before debug entry. The entry comes one halt cycle later with `dpc_sel_o` = 0. If that instruction raises an exception, its cause and value are saved at once, no trap redirect occurs, and debug entry follows with `dpc_sel_o` = 2 (trap target).
- R11: A completing write or set operation to the status or interrupt-enable CSR (`csr_crit_i`) gives one flush cycle with fetch clear and halt. The flush ends with a redirect with `pc_sel_o` = 1 (refetch next). Other CSR operations cause no flush. An interrupt pending during the flush cycle is taken instead of the refetch.
- R12: `rf_we_o` is `rf_we_dec_i` when an instruction is valid in the decode state and no illegal CSR operation is flagged. It is 0 otherwise.
- R13: A completing wait-for-interrupt outside debug mode holds fetch halted until an interrupt or debug request is pending. The controller then releases fetch without a redirect and serves the request at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid_i | input | 1 | Instruction valid in decode |
| id_busy_i | input | 1 | Valid instruction still running multiple cycles |
| exc_illegal_i | input | 1 | Illegal instruction exception |
| exc_load_i | input | 1 | Load fault exception |
| exc_store_i | input | 1 | Store fault exception |
| exc_ebreak_i | input | 1 | Breakpoint instruction |
| instr_word_i | input | XLEN | Instruction word in decode |
| fault_addr_i | input | XLEN | Faulting load/store address |
| csr_crit_i | input | 1 | Write/set of status or interrupt-enable CSR |
| csr_illegal_i | input | 1 | Illegal CSR operation |
| rf_we_dec_i | input | 1 | Register-file write request from decoder |
| wfi_i | input | 1 | Wait-for-interrupt instruction |
| dret_i | input | 1 | Debug-return instruction |
| irq_pending_i | input | 1 | Enabled interrupt pending |
| irq_id_i | input | IRQ_ID_W | Id of the pending interrupt |
| dbg_req_i | input | 1 | External debug halt request |
| dbg_step_i | input | 1 | Single-step enable |
| pc_set_o | output | 1 | PC redirect strobe |
| pc_sel_o | output | 3 | Redirect target select |
| csr_save_cause_o | output | 1 | Save cause and trap value |
| cause_o | output | CAUSE_W+1 | Cause: interrupt flag and code |
| tval_o | output | XLEN | Trap value |
| csr_save_dpc_o | output | 1 | Save debug PC |
| dpc_sel_o | output | 2 | Debug PC source select |
| fetch_clear_o | output | 1 | Clear fetch instruction-valid |
| fetch_halt_o | output | 1 | Stop pushing new instructions |
| debug_mode_o | output | 1 | Core is in debug mode |
| rf_we_o | output | 1 | Qualified register-file write enable |

## Verification
A wrong state register shows up within one or two cycles of the stimulus. It appears as a redirect to the wrong target, a save strobe that is missing or extra, or a halt that is held too long or released too early. Priority faults only appear when requests arrive together or meet a busy instruction, so the bench stacks a busy instruction, an exception, a debug request and an interrupt in one scenario. The bench also sweeps every combination of exception flags and every interrupt id. Debug-mode faults, such as a lost mode flag or an unmasked interrupt, appear in the cycle after the entry redirect as an interrupt being taken or a mode bit that is low.

// File: rtl/trapctl_pkg.sv
package trapctl_pkg;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_BOOT_SET,
    ST_FIRST_FETCH,
    ST_DECODE,
    ST_FLUSH,
    ST_IRQ_TAKEN,
    ST_HALT_WAIT,
    ST_DBG_ENTER,
    ST_SLEEP
  } ctl_state_e;

  typedef enum logic [2:0] {
    PC_BOOT    = 3'd0,
    PC_SEQ     = 3'd1,
    PC_TRAP    = 3'd2,
    PC_IRQ     = 3'd3,
    PC_DBG     = 3'd4,
    PC_DBG_EXC = 3'd5,
    PC_DRET    = 3'd6
  } pc_sel_e;

  typedef enum logic [1:0] {
    DPC_NEXT = 2'd0,
    DPC_CUR  = 2'd1,
    DPC_TRAP = 2'd2
  } dpc_sel_e;

  localparam int unsigned EXC_ILLEGAL     = 2;
  localparam int unsigned EXC_BREAK       = 3;
  localparam int unsigned EXC_LOAD_FAULT  = 5;
  localparam int unsigned EXC_STORE_FAULT = 7;

endpackage

// File: rtl/trapctl_cause.sv
module trapctl_cause
  import trapctl_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned CAUSE_W  = 5,
  parameter int unsigned IRQ_ID_W = 4
) (
  input  logic                exc_illegal_i,
  input  logic                exc_load_i,
  input  logic                exc_store_i,
  input  logic                exc_ebreak_i,
  input  logic [XLEN-1:0]     instr_word_i,
  input  logic [XLEN-1:0]     fault_addr_i,
  input  logic [IRQ_ID_W-1:0] irq_id_i,
  output logic                has_exc_o,
  output logic                is_ebreak_o,
  output logic [CAUSE_W:0]    exc_cause_o,
  output logic [XLEN-1:0]     exc_tval_o,
  output logic [CAUSE_W:0]    irq_cause_o
);

  // Fixed priority among simultaneous exception flags.
  always_comb begin
    has_exc_o   = exc_illegal_i | exc_load_i | exc_store_i | exc_ebreak_i;
    is_ebreak_o = exc_ebreak_i & ~exc_illegal_i;
    exc_cause_o = '0;
    exc_tval_o  = '0;
    if (exc_illegal_i) begin
      exc_cause_o = {1'b0, CAUSE_W'(EXC_ILLEGAL)};
      exc_tval_o  = instr_word_i;
    end else if (exc_ebreak_i) begin
      exc_cause_o = {1'b0, CAUSE_W'(EXC_BREAK)};
    end else if (exc_load_i) begin
      exc_cause_o = {1'b0, CAUSE_W'(EXC_LOAD_FAULT)};
      exc_tval_o  = fault_addr_i;
    end else if (exc_store_i) begin
      exc_cause_o = {1'b0, CAUSE_W'(EXC_STORE_FAULT)};
      exc_tval_o  = fault_addr_i;
    end
  end

  // Interrupt cause: flag bit plus the id, widened or trimmed to the code field.
  generate
    if (IRQ_ID_W < CAUSE_W) begin : g_irq_widen
      assign irq_cause_o = {1'b1, {(CAUSE_W-IRQ_ID_W){1'b0}}, irq_id_i};
    end else begin : g_irq_trim
      assign irq_cause_o = {1'b1, irq_id_i[CAUSE_W-1:0]};
    end
  endgenerate

endmodule

// File: rtl/trapctl_gate.sv
module trapctl_gate (
  input  logic debug_mode_i,
  input  logic irq_pending_i,
  input  logic dbg_req_i,
  input  logic dbg_step_i,
  input  logic wfi_i,
  output logic irq_ok_o,
  output logic dbg_ok_o,
  output logic step_ok_o,
  output logic wfi_ok_o
);

  // All requests are masked in debug mode, so the FSM needs no mode guards for them.
  always_comb begin
    irq_ok_o  = irq_pending_i & ~debug_mode_i;
    dbg_ok_o  = dbg_req_i     & ~debug_mode_i;
    step_ok_o = dbg_step_i    & ~debug_mode_i;
    wfi_ok_o  = wfi_i         & ~debug_mode_i;
  end

endmodule

// File: rtl/trap_dbg_ctrl.sv
module trap_dbg_ctrl
  import trapctl_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned CAUSE_W  = 5,
  parameter int unsigned IRQ_ID_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                id_valid_i,
  input  logic                id_busy_i,
  input  logic                exc_illegal_i,
  input  logic                exc_load_i,
  input  logic                exc_store_i,
  input  logic                exc_ebreak_i,
  input  logic [XLEN-1:0]     instr_word_i,
  input  logic [XLEN-1:0]     fault_addr_i,
  input  logic                csr_crit_i,
  input  logic                csr_illegal_i,
  input  logic                rf_we_dec_i,
  input  logic                wfi_i,
  input  logic                dret_i,
  input  logic                irq_pending_i,
  input  logic [IRQ_ID_W-1:0] irq_id_i,
  input  logic                dbg_req_i,
  input  logic                dbg_step_i,
  output logic                pc_set_o,
  output logic [2:0]          pc_sel_o,
  output logic                csr_save_cause_o,
  output logic [CAUSE_W:0]    cause_o,
  output logic [XLEN-1:0]     tval_o,
  output logic                csr_save_dpc_o,
  output logic [1:0]          dpc_sel_o,
  output logic                fetch_clear_o,
  output logic                fetch_halt_o,
  output logic                debug_mode_o,
  output logic                rf_we_o
);

  localparam int unsigned CW = CAUSE_W + 1;

  ctl_state_e      state_q, state_d;
  pc_sel_e         pc_sel_q, pc_sel_d;
  dpc_sel_e        dpc_sel_q, dpc_sel_d, dpc_pend_q, dpc_pend_d;
  logic            pc_set_q, pc_set_d;
  logic            save_cause_q, save_cause_d;
  logic            save_dpc_q, save_dpc_d;
  logic            clear_q, clear_d;
  logic            halt_q, halt_d;
  logic            dbg_mode_q, dbg_mode_d;
  logic [CW-1:0]   cause_q, cause_d, irq_hold_q, irq_hold_d;
  logic [XLEN-1:0] tval_q, tval_d;

  logic            has_exc, is_ebreak;
  logic [CW-1:0]   exc_cause, irq_cause;
  logic [XLEN-1:0] exc_tval;
  logic            irq_ok, dbg_ok, step_ok, wfi_ok;
  logic            done, take_req;

  trapctl_cause #(
    .XLEN     (XLEN),
    .CAUSE_W  (CAUSE_W),
    .IRQ_ID_W (IRQ_ID_W)
  ) u_cause (
    .exc_illegal_i (exc_illegal_i),
    .exc_load_i    (exc_load_i),
    .exc_store_i   (exc_store_i),
    .exc_ebreak_i  (exc_ebreak_i),
    .instr_word_i  (instr_word_i),
    .fault_addr_i  (fault_addr_i),
    .irq_id_i      (irq_id_i),
    .has_exc_o     (has_exc),
    .is_ebreak_o   (is_ebreak),
    .exc_cause_o   (exc_cause),
    .exc_tval_o    (exc_tval),
    .irq_cause_o   (irq_cause)
  );

  trapctl_gate u_gate (
    .debug_mode_i  (dbg_mode_q),
    .irq_pending_i (irq_pending_i),
    .dbg_req_i     (dbg_req_i),
    .dbg_step_i    (dbg_step_i),
    .wfi_i         (wfi_i),
    .irq_ok_o      (irq_ok),
    .dbg_ok_o      (dbg_ok),
    .step_ok_o     (step_ok),
    .wfi_ok_o      (wfi_ok)
  );

  assign done = id_valid_i & ~id_busy_i;

  always_comb begin
    state_d      = state_q;
    pc_set_d     = 1'b0;
    pc_sel_d     = pc_sel_q;
    save_cause_d = 1'b0;
    save_dpc_d   = 1'b0;
    clear_d      = 1'b0;
    cause_d      = cause_q;
    tval_d       = tval_q;
    dpc_sel_d    = dpc_sel_q;
    dpc_pend_d   = dpc_pend_q;
    dbg_mode_d   = dbg_mode_q;
    irq_hold_d   = irq_hold_q;
    take_req     = 1'b0;

    unique case (state_q)
      ST_RESET: state_d = ST_BOOT_SET;

      ST_BOOT_SET: begin
        pc_set_d = 1'b1;
        pc_sel_d = PC_BOOT;
        clear_d  = 1'b1;
        state_d  = ST_FIRST_FETCH;
      end

      ST_FIRST_FETCH: state_d = ST_DECODE;

      ST_DECODE: begin
        // The completing instruction and its exception come first.
        if (done) begin
          if (has_exc) begin
            if (dbg_mode_q) begin
              pc_set_d = 1'b1;
              pc_sel_d = PC_DBG_EXC;
              clear_d  = 1'b1;
            end else if (is_ebreak) begin
              dpc_pend_d = DPC_CUR;
              clear_d    = 1'b1;
              state_d    = ST_DBG_ENTER;
            end else begin
              save_cause_d = 1'b1;
              cause_d      = exc_cause;
              tval_d       = exc_tval;
              clear_d      = 1'b1;
              if (step_ok) begin
                dpc_pend_d = DPC_TRAP;
                state_d    = ST_DBG_ENTER;
              end else begin
                pc_set_d = 1'b1;
                pc_sel_d = PC_TRAP;
              end
            end
          end else if (dbg_mode_q && dret_i) begin
            pc_set_d   = 1'b1;
            pc_sel_d   = PC_DRET;
            clear_d    = 1'b1;
            dbg_mode_d = 1'b0;
          end else if (step_ok) begin
            dpc_pend_d = DPC_NEXT;
            clear_d    = 1'b1;
            state_d    = ST_DBG_ENTER;
          end else if (csr_crit_i) begin
            clear_d = 1'b1;
            state_d = ST_FLUSH;
          end else if (wfi_ok) begin
            clear_d = 1'b1;
            state_d = ST_SLEEP;
          end else begin
            take_req = 1'b1;
          end
        end else if (!id_valid_i) begin
          take_req = 1'b1;
        end
        // Requests are served only at a boundary: debug before interrupt.
        if (take_req) begin
          if (dbg_ok) begin
            clear_d = 1'b1;
            state_d = ST_HALT_WAIT;
          end else if (irq_ok) begin
            irq_hold_d = irq_cause;
            clear_d    = 1'b1;
            state_d    = ST_IRQ_TAKEN;
          end
        end
      end

      ST_FLUSH: begin
        if (dbg_ok) begin
          state_d = ST_HALT_WAIT;
        end else if (irq_ok) begin
          irq_hold_d = irq_cause;
          state_d    = ST_IRQ_TAKEN;
        end else begin
          pc_set_d = 1'b1;
          pc_sel_d = PC_SEQ;
          clear_d  = 1'b1;
          state_d  = ST_DECODE;
        end
      end

      ST_IRQ_TAKEN: begin
        pc_set_d     = 1'b1;
        pc_sel_d     = PC_IRQ;
        save_cause_d = 1'b1;
        cause_d      = irq_hold_q;
        tval_d       = '0;
        clear_d      = 1'b1;
        state_d      = ST_DECODE;
      end

      ST_HALT_WAIT: begin
        // Entry goes ahead only if the request is still present.
        if (dbg_ok) begin
          pc_set_d   = 1'b1;
          pc_sel_d   = PC_DBG;
          save_dpc_d = 1'b1;
          dpc_sel_d  = DPC_NEXT;
          dbg_mode_d = 1'b1;
          clear_d    = 1'b1;
        end
        state_d = ST_DECODE;
      end

      ST_DBG_ENTER: begin
        pc_set_d   = 1'b1;
        pc_sel_d   = PC_DBG;
        save_dpc_d = 1'b1;
        dpc_sel_d  = dpc_pend_q;
        dbg_mode_d = 1'b1;
        clear_d    = 1'b1;
        state_d    = ST_DECODE;
      end

      ST_SLEEP: begin
        if (irq_ok || dbg_ok) state_d = ST_DECODE;
      end

      default: state_d = ctl_state_e'('X);
    endcase

    halt_d = !(state_d inside {ST_DECODE, ST_FIRST_FETCH});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RESET;
      pc_set_q     <= 1'b0;
      pc_sel_q     <= PC_BOOT;
      save_cause_q <= 1'b0;
      save_dpc_q   <= 1'b0;
      clear_q      <= 1'b0;
      halt_q       <= 1'b1;
      cause_q      <= '0;
      tval_q       <= '0;
      dpc_sel_q    <= DPC_NEXT;
      dpc_pend_q   <= DPC_NEXT;
      dbg_mode_q   <= 1'b0;
      irq_hold_q   <= '0;
    end else begin
      state_q      <= state_d;
      pc_set_q     <= pc_set_d;
      pc_sel_q     <= pc_sel_d;
      save_cause_q <= save_cause_d;
      save_dpc_q   <= save_dpc_d;
      clear_q      <= clear_d;
      halt_q       <= halt_d;
      cause_q      <= cause_d;
      tval_q       <= tval_d;
      dpc_sel_q    <= dpc_sel_d;
      dpc_pend_q   <= dpc_pend_d;
      dbg_mode_q   <= dbg_mode_d;
      irq_hold_q   <= irq_hold_d;
    end
  end

  assign pc_set_o         = pc_set_q;
  assign pc_sel_o         = pc_sel_q;
  assign csr_save_cause_o = save_cause_q;
  assign cause_o          = cause_q;
  assign tval_o           = tval_q;
  assign csr_save_dpc_o   = save_dpc_q;
  assign dpc_sel_o        = dpc_sel_q;
  assign fetch_clear_o    = clear_q;
  assign fetch_halt_o     = halt_q;
  assign debug_mode_o     = dbg_mode_q;

  // Write enable qualifies the decoder's request in the same cycle.
  assign rf_we_o = rf_we_dec_i & id_valid_i & ~csr_illegal_i & (state_q == ST_DECODE);

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE && id_valid_i && id_busy_i) |=> (!pc_set_o && !fetch_clear_o));

  p_trap_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (pc_set_o && pc_sel_o == PC_TRAP) |-> (csr_save_cause_o && !cause_o[CAUSE_W]));

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (pc_set_o && pc_sel_o == PC_IRQ) |-> (csr_save_cause_o && cause_o[CAUSE_W] && tval_o == '0));

  p_dpc_entry_r6: assert property (@(posedge clk) disable iff (rst)
    csr_save_dpc_o |-> (pc_set_o && pc_sel_o == PC_DBG && debug_mode_o && !$past(debug_mode_o)));

  p_abandon_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT_WAIT && !dbg_req_i) |=> (!csr_save_dpc_o && !debug_mode_o && !pc_set_o));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_set_o && pc_sel_o == PC_IRQ) |-> !debug_mode_o);

  p_halt_clears_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_halt_o) |-> fetch_clear_o);

endmodule

// File: tb/trap_dbg_ctrl_tb.sv
module trap_dbg_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        id_valid_i, id_busy_i, exc_illegal_i, exc_load_i, exc_store_i, exc_ebreak_i;
  logic [31:0] instr_word_i, fault_addr_i;
  logic        csr_crit_i, csr_illegal_i, rf_we_dec_i, wfi_i, dret_i;
  logic        irq_pending_i;
  logic [3:0]  irq_id_i;
  logic        dbg_req_i, dbg_step_i;
  logic        pc_set_o, csr_save_cause_o, csr_save_dpc_o, fetch_clear_o, fetch_halt_o;
  logic        debug_mode_o, rf_we_o;
  logic [2:0]  pc_sel_o;
  logic [5:0]  cause_o;
  logic [31:0] tval_o;
  logic [1:0]  dpc_sel_o;

  int vectors = 0;
  int miss    = 0;
  bit ended   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_dbg_ctrl u_dut (
    .clk(clk), .rst(rst),
    .id_valid_i(id_valid_i), .id_busy_i(id_busy_i),
    .exc_illegal_i(exc_illegal_i), .exc_load_i(exc_load_i),
    .exc_store_i(exc_store_i), .exc_ebreak_i(exc_ebreak_i),
    .instr_word_i(instr_word_i), .fault_addr_i(fault_addr_i),
    .csr_crit_i(csr_crit_i), .csr_illegal_i(csr_illegal_i),
    .rf_we_dec_i(rf_we_dec_i), .wfi_i(wfi_i), .dret_i(dret_i),
    .irq_pending_i(irq_pending_i), .irq_id_i(irq_id_i),
    .dbg_req_i(dbg_req_i), .dbg_step_i(dbg_step_i),
    .pc_set_o(pc_set_o), .pc_sel_o(pc_sel_o),
    .csr_save_cause_o(csr_save_cause_o), .cause_o(cause_o), .tval_o(tval_o),
    .csr_save_dpc_o(csr_save_dpc_o), .dpc_sel_o(dpc_sel_o),
    .fetch_clear_o(fetch_clear_o), .fetch_halt_o(fetch_halt_o),
    .debug_mode_o(debug_mode_o), .rf_we_o(rf_we_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expo(input string tag, input bit set, input int sel, input bit sc,
                      input bit sd, input bit clr, input bit halt, input bit dbg);
    chk({tag, " pc_set"}, 64'(pc_set_o), 64'(set));
    if (set) chk({tag, " pc_sel"}, 64'(pc_sel_o), 64'(sel));
    chk({tag, " save_cause"}, 64'(csr_save_cause_o), 64'(sc));
    chk({tag, " save_dpc"}, 64'(csr_save_dpc_o), 64'(sd));
    chk({tag, " clear"}, 64'(fetch_clear_o), 64'(clr));
    chk({tag, " halt"}, 64'(fetch_halt_o), 64'(halt));
    chk({tag, " debug_mode"}, 64'(debug_mode_o), 64'(dbg));
  endtask

  task automatic idle();
    id_valid_i = 0; id_busy_i = 0; exc_illegal_i = 0; exc_load_i = 0; exc_store_i = 0;
    exc_ebreak_i = 0; instr_word_i = '0; fault_addr_i = '0; csr_crit_i = 0;
    csr_illegal_i = 0; rf_we_dec_i = 0; wfi_i = 0; dret_i = 0; irq_pending_i = 0;
    irq_id_i = '0; dbg_req_i = 0; dbg_step_i = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!ended) begin
      vectors++;
      miss++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    cyc(); cyc();
    expo("R1 in reset", 0, 0, 0, 0, 0, 1, 0);
    rst = 1'b0;
    cyc();
    expo("R1 post reset", 0, 0, 0, 0, 0, 1, 0);
    cyc();
    expo("R1 boot", 1, 0, 0, 0, 1, 0, 0);
    cyc();
    expo("R1 quiet", 0, 0, 0, 0, 0, 0, 0);

    // R4: sweep all exception flag combinations.
    for (int m = 1; m < 8; m++) begin
      logic [31:0] iw, fa;
      int code;
      idle();
      iw = 32'hA000_0000 + 32'(m);
      fa = 32'h0000_1000 * 32'(m);
      id_valid_i = 1; exc_illegal_i = m[0]; exc_load_i = m[1]; exc_store_i = m[2];
      instr_word_i = iw; fault_addr_i = fa;
      code = m[0] ? 2 : (m[1] ? 5 : 7);
      cyc();
      expo("R4 trap", 1, 2, 1, 0, 1, 0, 0);
      chk("R4 cause", 64'(cause_o), 64'(code));
      chk("R4 tval", 64'(tval_o), 64'(m[0] ? iw : fa));
      idle();
      cyc();
      expo("R4 after", 0, 0, 0, 0, 0, 0, 0);
    end

    // R5: sweep every interrupt id.
    for (int id = 0; id < 16; id++) begin
      idle();
      irq_pending_i = 1; irq_id_i = 4'(id);
      cyc();
      expo("R5 halt", 0, 0, 0, 0, 1, 1, 0);
      irq_pending_i = 0;
      cyc();
      expo("R5 redirect", 1, 3, 1, 0, 1, 0, 0);
      chk("R5 cause", 64'(cause_o), 64'(32 + id));
      chk("R5 tval", 64'(tval_o), 64'd0);
    end

    // R2 and R3: busy instruction holds off requests, then exception > debug > irq.
    idle();
    id_valid_i = 1; id_busy_i = 1; irq_pending_i = 1; irq_id_i = 4'd9; dbg_req_i = 1;
    for (int k = 0; k < 3; k++) begin
      cyc();
      expo("R2 busy", 0, 0, 0, 0, 0, 0, 0);
    end
    id_busy_i = 0; exc_illegal_i = 1; instr_word_i = 32'h0000_DEAD;
    cyc();
    expo("R3 exception first", 1, 2, 1, 0, 1, 0, 0);
    chk("R3 cause", 64'(cause_o), 64'd2);
    id_valid_i = 0; exc_illegal_i = 0;
    cyc();
    expo("R3 debug before irq", 0, 0, 0, 0, 1, 1, 0);
    cyc();
    expo("R6 entry", 1, 4, 0, 1, 1, 0, 1);
    chk("R6 dpc next", 64'(dpc_sel_o), 64'd0);
    dbg_req_i = 0;
    cyc();
    expo("R8 irq masked", 0, 0, 0, 0, 0, 0, 1);
    id_valid_i = 1; exc_load_i = 1;
    cyc();
    expo("R8 debug exception", 1, 5, 0, 0, 1, 0, 1);
    exc_load_i = 0; dret_i = 1;
    cyc();
    expo("R8 dret", 1, 6, 0, 0, 1, 0, 0);
    id_valid_i = 0; dret_i = 0;
    cyc();
    expo("R3 irq last", 0, 0, 0, 0, 1, 1, 0);
    irq_pending_i = 0;
    cyc();
    expo("R5 irq after debug", 1, 3, 1, 0, 1, 0, 0);
    chk("R5 cause id9", 64'(cause_o), 64'h29);

    // R7: request withdrawn during entry.
    idle();
    dbg_req_i = 1;
    cyc();
    expo("R7 halt", 0, 0, 0, 0, 1, 1, 0);
    dbg_req_i = 0;
    cyc();
    expo("R7 abandoned", 0, 0, 0, 0, 0, 0, 0);
    cyc();
    expo("R7 stays out", 0, 0, 0, 0, 0, 0, 0);

    // R9: breakpoint entry saves current PC.
    idle();
    id_valid_i = 1; exc_ebreak_i = 1;
    cyc();
    expo("R9 halt", 0, 0, 0, 0, 1, 1, 0);
    idle();
    cyc();
    expo("R9 entry", 1, 4, 0, 1, 1, 0, 1);
    chk("R9 dpc current", 64'(dpc_sel_o), 64'd1);
    id_valid_i = 1; dret_i = 1;
    cyc();
    expo("R9 exit", 1, 6, 0, 0, 1, 0, 0);

    // R10: single step.
    idle();
    dbg_step_i = 1; id_valid_i = 1; id_busy_i = 1;
    cyc();
    expo("R10 busy not aborted", 0, 0, 0, 0, 0, 0, 0);
    id_busy_i = 0;
    cyc();
    expo("R10 halt", 0, 0, 0, 0, 1, 1, 0);
    id_valid_i = 0;
    cyc();
    expo("R10 entry", 1, 4, 0, 1, 1, 0, 1);
    chk("R10 dpc next", 64'(dpc_sel_o), 64'd0);
    id_valid_i = 1; dret_i = 1;
    cyc();
    expo("R10 exit", 1, 6, 0, 0, 1, 0, 0);
    dret_i = 0; exc_store_i = 1; fault_addr_i = 32'h44;
    cyc();
    expo("R10 exc saved", 0, 0, 1, 0, 1, 1, 0);
    chk("R10 cause", 64'(cause_o), 64'd7);
    chk("R10 tval", 64'(tval_o), 64'h44);
    idle();
    cyc();
    expo("R10 exc entry", 1, 4, 0, 1, 1, 0, 1);
    chk("R10 dpc trap", 64'(dpc_sel_o), 64'd2);
    id_valid_i = 1; dret_i = 1;
    cyc();
    expo("R10 exc exit", 1, 6, 0, 0, 1, 0, 0);

    // R11: critical CSR flush.
    idle();
    id_valid_i = 1; csr_crit_i = 1;
    cyc();
    expo("R11 flush", 0, 0, 0, 0, 1, 1, 0);
    idle();
    cyc();
    expo("R11 refetch", 1, 1, 0, 0, 1, 0, 0);
    id_valid_i = 1;
    cyc();
    expo("R11 no flush", 0, 0, 0, 0, 0, 0, 0);
    csr_crit_i = 1;
    cyc();
    expo("R11 flush again", 0, 0, 0, 0, 1, 1, 0);
    idle();
    irq_pending_i = 1; irq_id_i = 4'd3;
    cyc();
    expo("R11 irq during flush", 0, 0, 0, 0, 0, 1, 0);
    irq_pending_i = 0;
    cyc();
    expo("R11 irq redirect", 1, 3, 1, 0, 1, 0, 0);
    chk("R11 irq cause", 64'(cause_o), 64'h23);

    // R12: write-enable qualification sweep.
    for (int c = 0; c < 8; c++) begin
      idle();
      rf_we_dec_i = c[0]; id_valid_i = c[1]; csr_illegal_i = c[2];
      #1;
      chk("R12 rf_we", 64'(rf_we_o), 64'(c[0] & c[1] & ~c[2]));
      cyc();
    end

    // R13: wait for interrupt.
    idle();
    id_valid_i = 1; wfi_i = 1;
    cyc();
    expo("R13 enter", 0, 0, 0, 0, 1, 1, 0);
    idle();
    #1;
    chk("R12 idle in sleep", 64'(rf_we_o), 64'd0);
    cyc();
    expo("R13 sleeping", 0, 0, 0, 0, 0, 1, 0);
    cyc();
    expo("R13 still sleeping", 0, 0, 0, 0, 0, 1, 0);
    irq_pending_i = 1; irq_id_i = 4'd1;
    cyc();
    expo("R13 wake", 0, 0, 0, 0, 0, 0, 0);
    cyc();
    expo("R13 irq taken", 0, 0, 0, 0, 1, 1, 0);
    irq_pending_i = 0;
    cyc();
    expo("R13 irq redirect", 1, 3, 1, 0, 1, 0, 0);
    chk("R13 cause", 64'(cause_o), 64'h21);

    finish_run();
  end

endmodule